// File: doc/BRIEF.md
# Predicated Tree Reduction Sequencer

This block sums up to `VLMAX` elements of a vector into one value. Only the elements whose predicate bit is set take part. It follows a fixed binary-tree schedule and performs one pairwise step per clock cycle. A caller presents the vector length, the packed element array and the predicate mask, then pulses `start`. The block copies all three into private working storage and runs the schedule. It then raises `done` for one cycle, with the sum, the element index that holds the sum, and a flag that says whether any element was active.

Element data never moves between slots. When the left member of a pair is inactive and its partner is active, the block does not copy the partner's value. It rewrites an entry of an internal index table so that later steps read through to the partner's storage. The order of additions is therefore fully fixed by the vector length and the mask.

Top module: `ptr_reduce_top`

## Requirements
- R1: An accepted `start` latches `vl`, `vec_in` (element k in bits `[k*EW +: EW]`) and `pred_in` (bit k for element k). Changing those ports afterwards has no effect on the result of that run.
- R2: The stride begins at 1 and is doubled before each pass. A further pass runs only while the stride, before doubling, is below `vl`. Each pass visits positions 0, s, 2s, … below `vl` at one per cycle, where s is the doubled stride. `done` is high N cycles after the start edge, where N is the total number of positions visited (N = 0 for `vl` of 0 or 1).
- R3: The partner of position i is i + s/2. The partner is active only when it is below `vl` and the working predicate bit at its table entry is set.
- R4: When the working predicate bit at position i's table entry is set and the partner is active, the partner's element is added into the element at position i's entry. The sum wraps modulo 2^EW.
- R5: When only the partner is active, the table entry for position i takes the partner's entry and no element is written.
- R6: After every step, the working predicate bit at position i's entry is ORed with the partner-active condition. Working predicate bits are never cleared during a run.
- R7: The index table starts every run as the identity, entry k equal to k.
- R8: `res_idx` is table entry 0, `sum_out` is the working element at that index, and `valid` is the working predicate bit there. An all-zero mask gives `valid` low.
- R9: `done` is high for exactly one cycle. The result outputs hold their values until the next accepted start. After reset, `done`, `valid`, `res_idx` and `sum_out` are zero.
- R10: `start` is ignored while a run is in progress or during the `done` cycle.
- R11: `vl` must not exceed `VLMAX` when `start` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a reduction when idle |
| vl | input | $clog2(VLMAX+1) | Number of elements to reduce |
| vec_in | input | VLMAX*EW | Packed element array |
| pred_in | input | VLMAX | Element predicate mask |
| sum_out | output | EW | Reduced sum |
| res_idx | output | max(1,$clog2(VLMAX)) | Element index holding the sum |
| valid | output | 1 | At least one element was active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `vl` never exceeds `VLMAX` while `start` is high. Without that bound, slot and partner positions could index past the working arrays. The bench draws every vector length from the range 0 to `VLMAX` and holds `vl` inside that range even while it drives stray starts during a run. Random cases mix dense, sparse and empty masks with full-range element values, so the wrap of R4 and the redirection of R5 both occur often.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_ADD   = 2'd1,
        ACT_REDIR = 2'd2
    } pair_act_e;

    function automatic int idx_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/ptr_sched.sv
module ptr_sched
    import ptr_pkg::*;
#(
    parameter int VLMAX = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [$clog2(VLMAX+1)-1:0]   vl,
    output logic                         load,
    output logic                         pair_en,
    output logic [$clog2(VLMAX)+1:0]     slot_pos,
    output logic [$clog2(VLMAX)+1:0]     part_pos,
    output logic [$clog2(VLMAX+1)-1:0]   vl_cur,
    output logic                         done
);
    localparam int VLW = $clog2(VLMAX + 1);
    localparam int SW  = $clog2(VLMAX) + 2;

    seq_state_e     state;
    logic [SW-1:0]  stride;
    logic [SW-1:0]  pos;
    logic [VLW-1:0] vl_q;
    logic [SW-1:0]  next_pos;
    logic [SW-1:0]  vl_ext;

    assign vl_ext   = SW'(vl_q);
    assign next_pos = pos + stride;
    assign load     = (state == SEQ_IDLE) && start;
    assign pair_en  = (state == SEQ_RUN);
    assign done     = (state == SEQ_DONE);
    assign slot_pos = pos;
    assign part_pos = pos + (stride >> 1);
    assign vl_cur   = vl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            stride <= '0;
            pos    <= '0;
            vl_q   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        vl_q   <= vl;
                        pos    <= '0;
                        stride <= SW'(2);
                        state  <= (vl > VLW'(1)) ? SEQ_RUN : SEQ_DONE;
                    end
                end
                SEQ_RUN: begin
                    if (next_pos >= vl_ext) begin
                        if (stride < vl_ext) begin
                            stride <= stride << 1;
                            pos    <= '0;
                        end else begin
                            state <= SEQ_DONE;
                        end
                    end else begin
                        pos <= next_pos;
                    end
                end
                SEQ_DONE: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    // R9: completion pulse lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: every visited slot lies below the latched length
    assert_slot_range_R2: assert property (@(posedge clk) disable iff (rst)
        pair_en |-> (slot_pos < vl_ext));

    // R11: caller keeps the length within the array
    assert_vl_range_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> (vl <= VLW'(VLMAX)));

    // R10: a start while busy does not relatch the length
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (start && state != SEQ_IDLE) |=> $stable(vl_q));

endmodule

// File: rtl/ptr_work.sv
module ptr_work
    import ptr_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int EW    = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 load,
    input  logic [VLMAX*EW-1:0]                  vec_in,
    input  logic [VLMAX-1:0]                     pred_in,
    input  logic                                 pair_en,
    input  logic [$clog2(VLMAX)+1:0]             slot_pos,
    input  logic [$clog2(VLMAX)+1:0]             part_pos,
    input  logic [$clog2(VLMAX+1)-1:0]           vl_cur,
    output logic [EW-1:0]                        res_sum,
    output logic [ptr_pkg::idx_bits(VLMAX)-1:0]  res_idx,
    output logic                                 res_valid
);
    localparam int IW = idx_bits(VLMAX);
    localparam int SW = $clog2(VLMAX) + 2;

    logic [VLMAX-1:0][EW-1:0] vec_w;
    logic [VLMAX-1:0]         pred_w;
    logic [VLMAX-1:0][IW-1:0] ix;

    logic [IW-1:0] slot_i;
    logic [IW-1:0] part_i;
    logic [IW-1:0] ci;
    logic [IW-1:0] oi;
    logic          part_in;
    logic          part_act;
    logic          slot_act;
    pair_act_e     act;

    assign slot_i   = slot_pos[IW-1:0];
    assign part_in  = part_pos < SW'(vl_cur);
    assign part_i   = part_in ? part_pos[IW-1:0] : '0;
    assign ci       = ix[slot_i];
    assign oi       = ix[part_i];
    assign part_act = part_in && pred_w[oi];
    assign slot_act = pred_w[ci];

    always_comb begin
        if (slot_act && part_act)
            act = ACT_ADD;
        else if (part_act)
            act = ACT_REDIR;
        else
            act = ACT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_w  <= '0;
            pred_w <= '0;
            ix     <= '0;
        end else if (load) begin
            pred_w <= pred_in;
            for (int k = 0; k < VLMAX; k++) begin
                vec_w[k] <= vec_in[k*EW +: EW];
                ix[k]    <= IW'(k);
            end
        end else if (pair_en) begin
            unique case (act)
                ACT_ADD:   vec_w[ci] <= vec_w[ci] + vec_w[oi];
                ACT_REDIR: ix[slot_i] <= oi;
                default:   ;
            endcase
            pred_w[ci] <= pred_w[ci] | part_act;
        end
    end

    assign res_idx   = ix[0];
    assign res_sum   = vec_w[ix[0]];
    assign res_valid = pred_w[ix[0]];

    // R6: working predicate bits only ever get set during a run
    assert_pred_monotone_R6: assert property (@(posedge clk) disable iff (rst)
        pair_en |=> ((pred_w & $past(pred_w)) == $past(pred_w)));

    // R5: a redirection step leaves every element untouched
    assert_redir_no_data_R5: assert property (@(posedge clk) disable iff (rst)
        (pair_en && act == ACT_REDIR) |=> $stable(vec_w));

    // R4: an addition step leaves the index table untouched
    assert_add_keeps_table_R4: assert property (@(posedge clk) disable iff (rst)
        (pair_en && act == ACT_ADD) |=> $stable(ix));

    // R9: outside a load or a step, the whole working state holds
    assert_hold_state_R9: assert property (@(posedge clk) disable iff (rst)
        (!pair_en && !load) |=> ($stable(vec_w) && $stable(pred_w) && $stable(ix)));

endmodule

// File: rtl/ptr_reduce_top.sv
module ptr_reduce_top
    import ptr_pkg::*;
#(
    parameter int VLMAX = 8,
    parameter int EW    = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 start,
    input  logic [$clog2(VLMAX+1)-1:0]           vl,
    input  logic [VLMAX*EW-1:0]                  vec_in,
    input  logic [VLMAX-1:0]                     pred_in,
    output logic [EW-1:0]                        sum_out,
    output logic [ptr_pkg::idx_bits(VLMAX)-1:0]  res_idx,
    output logic                                 valid,
    output logic                                 done
);
    localparam int VLW = $clog2(VLMAX + 1);
    localparam int SW  = $clog2(VLMAX) + 2;

    logic           load;
    logic           pair_en;
    logic [SW-1:0]  slot_pos;
    logic [SW-1:0]  part_pos;
    logic [VLW-1:0] vl_cur;

    ptr_sched #(.VLMAX(VLMAX)) u_sched (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vl       (vl),
        .load     (load),
        .pair_en  (pair_en),
        .slot_pos (slot_pos),
        .part_pos (part_pos),
        .vl_cur   (vl_cur),
        .done     (done)
    );

    ptr_work #(.VLMAX(VLMAX), .EW(EW)) u_work (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .vec_in    (vec_in),
        .pred_in   (pred_in),
        .pair_en   (pair_en),
        .slot_pos  (slot_pos),
        .part_pos  (part_pos),
        .vl_cur    (vl_cur),
        .res_sum   (sum_out),
        .res_idx   (res_idx),
        .res_valid (valid)
    );

    // R8: an empty mask can never report a valid result at completion
    assert_empty_invalid_R8: assert property (@(posedge clk) disable iff (rst)
        (load && pred_in == '0) |=> (!valid));

endmodule

// File: tb/ptr_reduce_top_tb.sv
module ptr_reduce_top_tb;
    localparam int VLMAX = 8;
    localparam int EW    = 16;
    localparam int VLW   = $clog2(VLMAX + 1);
    localparam int IW    = $clog2(VLMAX);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  start = 1'b0;
    logic [VLW-1:0]        vl = '0;
    logic [VLMAX*EW-1:0]   vec_in = '0;
    logic [VLMAX-1:0]      pred_in = '0;
    logic [EW-1:0]         sum_out;
    logic [IW-1:0]         res_idx;
    logic                  valid;
    logic                  done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_reduce_top #(.VLMAX(VLMAX), .EW(EW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .vl(vl), .vec_in(vec_in),
        .pred_in(pred_in), .sum_out(sum_out), .res_idx(res_idx),
        .valid(valid), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model(input int n, input logic [VLMAX*EW-1:0] vf,
                         input logic [VLMAX-1:0] pm,
                         output logic [EW-1:0] s, output int idx,
                         output bit val, output int pairs);
        logic [EW-1:0] v [VLMAX];
        bit            p [VLMAX];
        int            ix [VLMAX];
        int            step, other, ci, oi;
        bit            opd;
        for (int k = 0; k < VLMAX; k++) begin
            v[k]  = vf[k*EW +: EW];
            p[k]  = pm[k];
            ix[k] = k;
        end
        step  = 1;
        pairs = 0;
        while (step < n) begin
            step = step * 2;
            for (int i = 0; i < n; i += step) begin
                pairs++;
                other = i + step / 2;
                ci    = ix[i];
                oi    = 0;
                opd   = 1'b0;
                if (other < n) begin
                    oi  = ix[other];
                    opd = p[oi];
                end
                if (p[ci] && opd)
                    v[ci] = v[ci] + v[oi];
                else if (opd)
                    ix[i] = oi;
                p[ci] = p[ci] | opd;
            end
        end
        idx = ix[0];
        s   = v[idx];
        val = p[idx];
    endtask

    // One full reduction; disturb=1 keeps start high and scrambles inputs mid-run.
    task automatic run(input int n, input logic [VLMAX*EW-1:0] vf,
                       input logic [VLMAX-1:0] pm, input bit disturb);
        logic [EW-1:0] es;
        int            ei, np, cnt;
        bit            ev;
        logic [EW-1:0] hs;
        logic [IW-1:0] hi;
        logic          hv;
        model(n, vf, pm, es, ei, ev, np);
        @(negedge clk);
        vl      = VLW'(n);
        vec_in  = vf;
        pred_in = pm;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = disturb;
        if (disturb) begin
            vec_in  = ~vf;
            pred_in = ~pm;
            vl      = VLW'(VLMAX - n);
        end
        cnt = 0;
        while (!done && cnt < 4 * VLMAX) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        check("R2 latency", cnt, np);
        check("R4 sum", sum_out, es);
        check("R5 R7 result index", res_idx, ei);
        check("R3 R6 R8 valid", valid, ev);
        if (disturb) check("R1 R10 ignored start/inputs done", done, 1);
        hs = sum_out; hi = res_idx; hv = valid;
        @(posedge clk);
        @(negedge clk);
        check("R9 done single cycle", done, 0);
        check("R9 result held", {hv, hi, hs} == {valid, res_idx, sum_out}, 1);
    endtask

    initial begin
        logic [VLMAX*EW-1:0] vf;
        logic [VLMAX-1:0]    pm;
        void'($urandom(32'd20250611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset done", done, 0);
        check("R9 reset valid", valid, 0);
        check("R9 reset index", res_idx, 0);
        check("R9 reset sum", sum_out, 0);

        for (int k = 0; k < VLMAX; k++) vf[k*EW +: EW] = EW'(k * 3 + 1);
        run(VLMAX, vf, '1, 1'b0);          // R4 dense full-length
        run(VLMAX, vf, '0, 1'b0);          // R8 empty mask
        run(0, vf, '1, 1'b0);              // R2 zero length
        run(1, vf, 8'h01, 1'b0);           // R2 single element
        run(VLMAX, vf, 8'h20, 1'b0);       // R5 lone element at index 5
        run(5, vf, 8'h1A, 1'b0);           // R3 partner beyond length
        run(VLMAX, vf, 8'hC1, 1'b1);       // R1 R10 disturbed run
        for (int k = 0; k < VLMAX; k++) vf[k*EW +: EW] = '1;
        run(VLMAX, vf, '1, 1'b0);          // R4 wrap

        for (int t = 0; t < 40; t++) begin
            for (int k = 0; k < VLMAX; k++) vf[k*EW +: EW] = EW'($urandom);
            pm = VLMAX'($urandom);
            if (t % 4 == 1) pm = pm & VLMAX'($urandom);
            run($urandom_range(0, VLMAX), vf, pm, (t % 5) == 2);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule